// File: doc/BRIEF.md
# Multi-Master I2C Byte Transmitter with Arbitration Loss

This block is the transmit side of an I2C master that shares its bus with other masters. It drives SCL and SDA only through open-drain output enables and reads back the resolved line levels. Software issues single-cycle command strobes for start, repeated start, stop and a master acknowledge bit. It loads a transmit byte through a write strobe. The block then sequences each bit in four quarter phases, whose length comes from a run-time divider.

Each time the block leaves SDA released to signal a one, it reads the line back while SCL is high. A low level means another master won the bus. The same check runs during data bits, the master acknowledge bit, start, repeated start and stop. When arbitration is lost, the block drops every command in flight, empties its transmit buffer, releases both lines and returns to idle. It also raises a sticky collision flag. A line monitor keeps tracking start and stop conditions on the bus, so software can tell when the bus is free again. The next byte after a loss always begins at its most significant bit.

Top module: `i2c_arb_master`

## Requirements
- R1: After reset both output enables are 0, buf_full_o is 0, pend_o is 0, bcol_o is 0, stop_irq_o is 0, ack_o is 1 and bus_free_o is 1.
- R2: A byte goes out MSB first, and each bit is steady on SDA at the SCL rising edge. A ninth slot leaves SDA released, and the line level seen in that slot is stored in ack_o (0 = acknowledged).
- R3: A write strobe sets buf_full_o. A write while buf_full_o is 1 is ignored. buf_full_o clears when the ninth slot of the byte ends.
- R4: A start sequence takes SDA low while SCL is high, then holds SCL low. The line monitor then reports start_seen_o=1 and stop_seen_o=0.
- R5: A rise on SDA while SCL is high sets stop_seen_o and a sticky stop_irq_o. stop_irq_o stays set until irq_clr_i is pulsed, and it is also set by a stop that another master drives after a collision.
- R6: If SDA reads low while SCL is high during a data bit the block sent as 1, the block sets bcol_o, clears buf_full_o and pend_o, releases both lines and returns to idle.
- R7: A collision during a start, repeated start, stop or master acknowledge bit aborts that sequence, clears pend_o, releases both lines and sets bcol_o. During a stop, the collision is an SDA level that reads low after the stop releases it.
- R8: A start strobe is refused, and bcol_o is set with no line driven, when the bus is not free or when SCL or SDA is already low.
- R9: bcol_o stays set until bcol_clr_i is pulsed. Clearing it in idle leaves both output enables at 0.
- R10: After a collision, the next start and byte write send the new byte from its MSB.
- R11: The acknowledge command sends ack_val_i as one bit. The repeated-start command produces a new start without an intermediate stop.
- R12: pend_o bit 0 is start, bit 1 is repeated start, bit 2 is stop and bit 3 is acknowledge. A bit is set when its command is accepted and cleared when the sequence ends. At most one bit is set at a time.
- R13: bus_free_o is 1 when the last condition seen was a stop, or when neither a start nor a stop has been seen since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| qtr_div_i | input | DIV_W | Quarter-phase length minus one, in clock cycles (at least 3) |
| scl_i | input | 1 | Resolved SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| wr_i | input | 1 | Transmit byte write strobe |
| wdata_i | input | DATA_W | Transmit byte |
| buf_full_o | output | 1 | Transmit buffer holds a byte not yet sent |
| start_i | input | 1 | Start command strobe |
| rstart_i | input | 1 | Repeated-start command strobe |
| stop_i | input | 1 | Stop command strobe |
| ack_i | input | 1 | Master acknowledge command strobe |
| ack_val_i | input | 1 | Bit value sent by the acknowledge command |
| pend_o | output | 4 | Pending command bits {ack, stop, rstart, start} |
| ack_o | output | 1 | Level sampled in the last ninth slot |
| bcol_o | output | 1 | Sticky bus collision flag |
| bcol_clr_i | input | 1 | Clears bcol_o |
| start_seen_o | output | 1 | Last bus condition seen was a start |
| stop_seen_o | output | 1 | Last bus condition seen was a stop |
| bus_free_o | output | 1 | Bus may be claimed |
| stop_irq_o | output | 1 | Sticky stop-detected flag |
| irq_clr_i | input | 1 | Clears stop_irq_o |

## Verification
The properties assume that software issues a command strobe only when the master is idle or holding SCL low with nothing pending. They also assume that qtr_div_i is at least 3, so the two-flop line samples settle inside one quarter, and that no device stretches SCL while the master is clocking a bit. The stimulus follows these rules: it waits for pend_o and buf_full_o to drain before each new command. The external SCL pull is used only while the master is idle, to build a busy or low-line condition for refused starts. Rival traffic only pulls SDA low, either while SCL is low or over an SDA level the master has released, and a release with SCL high then forms a stop.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_START, ST_STOP, ST_DATA, ST_MACK
  } mst_state_e;

  localparam int unsigned PEND_START  = 0;
  localparam int unsigned PEND_RSTART = 1;
  localparam int unsigned PEND_STOP   = 2;
  localparam int unsigned PEND_ACK    = 3;
  localparam int unsigned PEND_W      = 4;
endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic irq_clr_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic start_seen_o,
  output logic stop_seen_o,
  output logic bus_free_o,
  output logic stop_irq_o
);
  logic [SYNC_N-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p, start_det, stop_det;
  logic start_q, stop_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_N-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_N-2:0], sda_i};
      scl_p  <= scl_ff[SYNC_N-1];
      sda_p  <= sda_ff[SYNC_N-1];
    end
  end

  assign scl_s_o = scl_ff[SYNC_N-1];
  assign sda_s_o = sda_ff[SYNC_N-1];

  // conditions only count with SCL high on both samples
  assign start_det = scl_p & scl_s_o & sda_p & ~sda_s_o;
  assign stop_det  = scl_p & scl_s_o & ~sda_p & sda_s_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (start_det) begin
        start_q <= 1'b1;
        stop_q  <= 1'b0;
      end else if (stop_det) begin
        start_q <= 1'b0;
        stop_q  <= 1'b1;
      end
      if (stop_det)       irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign start_seen_o = start_q;
  assign stop_seen_o  = stop_q;
  assign stop_irq_o   = irq_q;
  assign bus_free_o   = stop_q | (~start_q & ~stop_q);
endmodule

// File: rtl/i2c_qtr_gen.sv
module i2c_qtr_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= div_i;
    else if (cnt_q == '0)   cnt_q <= div_i;
    else                    cnt_q <= cnt_q - DIV_W'(1);
  end

  assign tick_o = en_i && (cnt_q == '0);
endmodule

// File: rtl/i2c_arb_master.sv
module i2c_arb_master
  import i2c_arb_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  qtr_div_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              buf_full_o,
  input  logic              start_i,
  input  logic              rstart_i,
  input  logic              stop_i,
  input  logic              ack_i,
  input  logic              ack_val_i,
  output logic [3:0]        pend_o,
  output logic              ack_o,
  output logic              bcol_o,
  input  logic              bcol_clr_i,
  output logic              start_seen_o,
  output logic              stop_seen_o,
  output logic              bus_free_o,
  output logic              stop_irq_o,
  input  logic              irq_clr_i
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DATA_W);

  mst_state_e        state_q;
  logic [1:0]        qph_q;
  logic [CNT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sr_q, buf_q;
  logic              buf_full_q, rs_q, ackv_q, hold_low_q, ack_q, bcol_q;
  logic [PEND_W-1:0] pend_q;

  logic scl_s, sda_s, tick, run, qend2, qend3, lost, start_ok, tx_bit;
  logic scl_drv, sda_drv;

  i2c_line_mon #(.SYNC_N(SYNC_N)) u_mon (
    .clk_i, .rst_ni, .scl_i, .sda_i, .irq_clr_i,
    .scl_s_o(scl_s), .sda_s_o(sda_s),
    .start_seen_o, .stop_seen_o, .bus_free_o, .stop_irq_o
  );

  assign run = (state_q == ST_START) || (state_q == ST_STOP) ||
               (state_q == ST_DATA)  || (state_q == ST_MACK);

  i2c_qtr_gen #(.DIV_W(DIV_W)) u_qtr (
    .clk_i, .rst_ni, .en_i(run), .div_i(qtr_div_i), .tick_o(tick)
  );

  assign qend2 = tick && (qph_q == 2'd2);
  assign qend3 = tick && (qph_q == 2'd3);

  // quarters 0,1: SCL low; 2,3: SCL released
  always_comb begin
    scl_drv = 1'b0;
    sda_drv = 1'b0;
    tx_bit  = 1'b1;
    unique case (state_q)
      ST_HOLD: begin
        scl_drv = 1'b1;
        sda_drv = hold_low_q;
      end
      ST_START: begin
        scl_drv = (qph_q == 2'd0) && rs_q;
        sda_drv = (qph_q == 2'd3);
      end
      ST_STOP: begin
        scl_drv = (qph_q == 2'd0);
        sda_drv = (qph_q != 2'd3);
      end
      ST_DATA: begin
        tx_bit  = (bit_q == LAST_SLOT) ? 1'b1 : sr_q[DATA_W-1];
        scl_drv = !qph_q[1];
        sda_drv = !tx_bit;
      end
      ST_MACK: begin
        tx_bit  = ackv_q;
        scl_drv = !qph_q[1];
        sda_drv = !tx_bit;
      end
      default: ;
    endcase
  end

  assign lost = (qend2 && !sda_s &&
                  ((state_q == ST_START) ||
                   (state_q == ST_DATA && bit_q != LAST_SLOT && tx_bit) ||
                   (state_q == ST_MACK && tx_bit))) ||
                (qend3 && !sda_s && state_q == ST_STOP);

  assign start_ok = bus_free_o && scl_s && sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      qph_q      <= '0;
      bit_q      <= '0;
      sr_q       <= '0;
      buf_q      <= '0;
      buf_full_q <= 1'b0;
      rs_q       <= 1'b0;
      ackv_q     <= 1'b1;
      hold_low_q <= 1'b0;
      pend_q     <= '0;
      ack_q      <= 1'b1;
      bcol_q     <= 1'b0;
    end else begin
      if (tick)       qph_q  <= qph_q + 2'd1;
      if (bcol_clr_i) bcol_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          qph_q <= '0;
          if (start_i) begin
            if (start_ok) begin
              state_q            <= ST_START;
              rs_q               <= 1'b0;
              pend_q[PEND_START] <= 1'b1;
            end else begin
              bcol_q <= 1'b1;
            end
          end
        end
        ST_HOLD: begin
          qph_q <= '0;
          if (rstart_i) begin
            state_q             <= ST_START;
            rs_q                <= 1'b1;
            pend_q[PEND_RSTART] <= 1'b1;
          end else if (stop_i) begin
            state_q           <= ST_STOP;
            pend_q[PEND_STOP] <= 1'b1;
          end else if (ack_i) begin
            state_q          <= ST_MACK;
            ackv_q           <= ack_val_i;
            pend_q[PEND_ACK] <= 1'b1;
          end else if (buf_full_q) begin
            state_q <= ST_DATA;
            sr_q    <= buf_q;
            bit_q   <= '0;
          end
        end
        ST_START: if (qend3) begin
          state_q             <= ST_HOLD;
          hold_low_q          <= 1'b1;
          pend_q[PEND_START]  <= 1'b0;
          pend_q[PEND_RSTART] <= 1'b0;
        end
        ST_STOP: if (qend3) begin
          state_q           <= ST_IDLE;
          pend_q[PEND_STOP] <= 1'b0;
        end
        ST_DATA: begin
          if (qend2 && bit_q == LAST_SLOT) ack_q <= sda_s;
          if (qend3) begin
            if (bit_q == LAST_SLOT) begin
              state_q    <= ST_HOLD;
              hold_low_q <= 1'b0;
              buf_full_q <= 1'b0;
            end else begin
              bit_q <= bit_q + CNT_W'(1);
              sr_q  <= {sr_q[DATA_W-2:0], 1'b0};
            end
          end
        end
        ST_MACK: if (qend3) begin
          state_q          <= ST_HOLD;
          hold_low_q       <= !ackv_q;
          pend_q[PEND_ACK] <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (lost) begin
        state_q    <= ST_IDLE;
        qph_q      <= '0;
        pend_q     <= '0;
        buf_full_q <= 1'b0;
        bcol_q     <= 1'b1;
      end
      if (wr_i && !buf_full_q) begin
        buf_q      <= wdata_i;
        buf_full_q <= 1'b1;
      end
    end
  end

  assign scl_oe_o   = scl_drv;
  assign sda_oe_o   = sda_drv;
  assign buf_full_o = buf_full_q;
  assign pend_o     = pend_q;
  assign ack_o      = ack_q;
  assign bcol_o     = bcol_q;
endmodule

// File: rtl/i2c_arb_chk.sv
module i2c_arb_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_oe_o,
  input logic       sda_oe_o,
  input logic       buf_full_o,
  input logic       start_i,
  input logic [3:0] pend_o,
  input logic       bcol_o,
  input logic       bcol_clr_i,
  input logic       start_seen_o,
  input logic       stop_seen_o,
  input logic       bus_free_o,
  input logic       stop_irq_o,
  input logic       irq_clr_i
);
  p_col_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bcol_o) |-> (!scl_oe_o && !sda_oe_o && pend_o == 4'd0));

  p_bcol_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcol_o && !bcol_clr_i) |=> bcol_o);

  p_clr_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcol_clr_i && !start_i && !scl_oe_o && !sda_oe_o && pend_o == 4'd0 && !buf_full_o)
    |=> (!scl_oe_o && !sda_oe_o));

  p_refuse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !bus_free_o && !scl_oe_o && !sda_oe_o && pend_o == 4'd0 && !buf_full_o)
    |=> (bcol_o && pend_o == 4'd0));

  p_irq_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_irq_o && !irq_clr_i) |=> stop_irq_o);

  p_stop_free_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_seen_o |-> bus_free_o);

  p_seen_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_seen_o && stop_seen_o));

  p_pend_one_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pend_o));
endmodule

bind i2c_arb_master i2c_arb_chk u_chk (.*);

// File: tb/sim_i2c_arb_master.sv
module sim_i2c_arb_master;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] qtr_div = 8'd4;
  logic scl_oe, sda_oe, ext_scl = 1'b0, ext_sda = 1'b0;
  logic scl_bus, sda_bus;
  logic wr = 1'b0, start = 1'b0, rstart = 1'b0, stop = 1'b0, ack = 1'b0, ack_val = 1'b0;
  logic bcol_clr = 1'b0, irq_clr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic buf_full, ack_rx, bcol, start_seen, stop_seen, bus_free, stop_irq;
  logic [3:0] pend;

  assign scl_bus = !(scl_oe | ext_scl);
  assign sda_bus = !(sda_oe | ext_sda);

  i2c_arb_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .qtr_div_i(qtr_div),
    .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .wr_i(wr), .wdata_i(wdata), .buf_full_o(buf_full),
    .start_i(start), .rstart_i(rstart), .stop_i(stop), .ack_i(ack), .ack_val_i(ack_val),
    .pend_o(pend), .ack_o(ack_rx), .bcol_o(bcol), .bcol_clr_i(bcol_clr),
    .start_seen_o(start_seen), .stop_seen_o(stop_seen), .bus_free_o(bus_free),
    .stop_irq_o(stop_irq), .irq_clr_i(irq_clr)
  );

  int n_cmp = 0, n_bad = 0;
  bit exp_q[$];

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model: expected SDA level at each SCL rise
  always @(posedge scl_bus) begin
    if (exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      check("R2 bit at SCL rise", int'(sda_bus), int'(e));
    end
  end

  task automatic cmd(int which);
    @(negedge clk);
    case (which)
      0: start = 1'b1;
      1: rstart = 1'b1;
      2: stop = 1'b1;
      3: ack = 1'b1;
      4: bcol_clr = 1'b1;
      default: irq_clr = 1'b1;
    endcase
    @(negedge clk);
    {start, rstart, stop, ack, bcol_clr, irq_clr} = '0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (pend != 4'd0 || buf_full);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic send_byte(logic [7:0] d, bit sack, bit try_over);
    for (int i = 7; i >= 0; i--) exp_q.push_back(d[i]);
    exp_q.push_back(sack ? 1'b0 : 1'b1);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
    check("R3 buf_full after write", int'(buf_full), 1);
    if (try_over) begin
      wr = 1'b1; wdata = ~d;
      @(negedge clk); wr = 1'b0;
    end
    repeat (8) @(posedge scl_bus);
    @(negedge scl_bus);
    if (sack) ext_sda = 1'b1;
    @(negedge scl_bus);
    ext_sda = 1'b0;
    wait_done();
    check("R3 buf_full cleared", int'(buf_full), 0);
    check("R2 ack sampled", int'(ack_rx), sack ? 0 : 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 scl_oe", int'(scl_oe), 0);
    check("R1 sda_oe", int'(sda_oe), 0);
    check("R1 buf_full", int'(buf_full), 0);
    check("R1 pend", int'(pend), 0);
    check("R1 bcol", int'(bcol), 0);
    check("R1 stop_irq", int'(stop_irq), 0);
    check("R1 ack", int'(ack_rx), 1);
    check("R1 R13 bus_free", int'(bus_free), 1);

    // normal transfer
    cmd(0);
    check("R12 start pending", int'(pend), 1);
    wait_done(); settle();
    check("R4 start_seen", int'(start_seen), 1);
    check("R4 stop_seen", int'(stop_seen), 0);
    check("R13 busy after start", int'(bus_free), 0);
    check("R4 scl held low", int'(scl_oe), 1);
    send_byte(8'hA5, 1'b1, 1'b1);
    send_byte(8'h3C, 1'b0, 1'b0);
    exp_q.push_back(1'b0);
    ack_val = 1'b0;
    cmd(3);
    check("R12 ack pending", int'(pend), 8);
    wait_done();
    check("R11 ack bit consumed", exp_q.size(), 0);
    cmd(1);
    check("R12 rstart pending", int'(pend), 2);
    wait_done(); settle();
    check("R11 rstart start_seen", int'(start_seen), 1);
    check("R11 rstart no stop", int'(stop_seen), 0);
    cmd(2);
    check("R12 stop pending", int'(pend), 4);
    wait_done(); settle();
    check("R5 stop_seen", int'(stop_seen), 1);
    check("R5 stop_irq", int'(stop_irq), 1);
    check("R13 free after stop", int'(bus_free), 1);
    check("R5 lines released", int'({scl_oe, sda_oe}), 0);
    check("R9 no collision", int'(bcol), 0);
    settle();
    check("R5 irq sticky", int'(stop_irq), 1);
    cmd(5);
    check("R5 irq cleared", int'(stop_irq), 0);

    // lost arbitration on third data bit
    cmd(0); wait_done();
    exp_q.push_back(1'b1); exp_q.push_back(1'b0);
    @(negedge clk); wr = 1'b1; wdata = 8'hA5;
    @(negedge clk); wr = 1'b0;
    repeat (2) @(posedge scl_bus);
    @(negedge scl_bus);
    ext_sda = 1'b1;
    while (!bcol) @(negedge clk);
    check("R6 bcol", int'(bcol), 1);
    check("R6 buf_full cleared", int'(buf_full), 0);
    check("R6 pend cleared", int'(pend), 0);
    check("R6 lines released", int'({scl_oe, sda_oe}), 0);
    settle();
    check("R6 still idle", int'({scl_oe, sda_oe}), 0);
    ext_sda = 1'b0;
    settle();
    check("R5 stop after collision", int'(stop_irq), 1);
    check("R13 free again", int'(bus_free), 1);
    check("R9 bcol sticky", int'(bcol), 1);
    cmd(4);
    check("R9 bcol cleared", int'(bcol), 0);
    check("R9 idle kept", int'({scl_oe, sda_oe}), 0);
    cmd(5);

    // next byte restarts from MSB
    cmd(0); wait_done();
    send_byte(8'hA5, 1'b1, 1'b0);
    check("R10 full byte from MSB", exp_q.size(), 0);
    cmd(2); wait_done(); settle();

    // collision during stop
    cmd(0); wait_done();
    cmd(2);
    ext_sda = 1'b1;
    wait_done();
    check("R7 stop collision bcol", int'(bcol), 1);
    check("R7 stop pend cleared", int'(pend), 0);
    check("R7 stop lines released", int'({scl_oe, sda_oe}), 0);
    ext_sda = 1'b0; settle();
    cmd(4); cmd(5);

    // collision during master acknowledge
    cmd(0); wait_done();
    send_byte(8'h5A, 1'b1, 1'b0);
    ack_val = 1'b1;
    cmd(3);
    ext_sda = 1'b1;
    wait_done();
    check("R7 ack collision bcol", int'(bcol), 1);
    check("R7 ack pend cleared", int'(pend), 0);
    check("R7 ack lines released", int'({scl_oe, sda_oe}), 0);
    ext_sda = 1'b0; settle();
    cmd(4); cmd(5);

    // collision during start
    cmd(0);
    ext_sda = 1'b1;
    wait_done();
    check("R7 start collision bcol", int'(bcol), 1);
    check("R7 start pend cleared", int'(pend), 0);
    check("R7 start lines released", int'({scl_oe, sda_oe}), 0);
    ext_sda = 1'b0; settle();
    cmd(4); cmd(5);

    // refused start: bus busy with both lines high
    ext_sda = 1'b1; settle();
    ext_scl = 1'b1; settle();
    ext_sda = 1'b0; settle();
    ext_scl = 1'b0; settle();
    check("R13 busy after foreign start", int'(bus_free), 0);
    cmd(0);
    check("R8 busy refused bcol", int'(bcol), 1);
    check("R8 busy no pend", int'(pend), 0);
    check("R8 busy no drive", int'({scl_oe, sda_oe}), 0);
    cmd(4);
    ext_sda = 1'b1; settle();
    ext_sda = 1'b0; settle();
    check("R13 free after foreign stop", int'(bus_free), 1);

    // refused start: SCL held low
    ext_scl = 1'b1; settle();
    cmd(0);
    check("R8 low line refused bcol", int'(bcol), 1);
    check("R8 low line no pend", int'(pend), 0);
    check("R8 low line no drive", int'({scl_oe, sda_oe}), 0);
    ext_scl = 1'b0; settle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule